// File: doc/BRIEF.md
# Jump Condition and Program Counter Unit

This unit resolves the jump instructions of a 64-bit register machine whose instructions each take one 64-bit slot. Each accepted instruction brings an 8-bit opcode, a first operand (destination register), a second operand (source register), a 32-bit immediate and a signed 16-bit offset. The unit evaluates the branch predicate, moves its own program counter and reports a set of result flags. The low three opcode bits give the class: 0x05 is the 64-bit jump class and 0x06 is the 32-bit jump class. Opcode bit 3 picks the second operand. The top four bits give the condition code.

Instructions arrive with `op_valid`. The unit has no ready signal and accepts one instruction on every cycle that `op_valid` is high. An upstream stage therefore never waits, and it may issue back to back. One cycle after acceptance, `res_valid` is high for one cycle. In that cycle the flags are valid and `pc_o` already holds the next program counter. The unit does not resolve call targets and does not return from calls. It only flags these cases.

Top module: `bcu_branch_unit`

## Requirements
- R1: After reset, `pc_o` is 0, and `res_valid`, `taken_o`, `call_o`, `ret_o` and `bad_o` are all 0.
- R2: Class 0x05 (opcode[2:0]=5) compares the full 64-bit operands. Class 0x06 (opcode[2:0]=6) compares only bits 31:0 of both operands, using the same condition codes.
- R3: Opcode bit 3 = 1 selects the source register as the second operand. Bit 3 = 0 selects the immediate, sign-extended from bit 31 to the compare width.
- R4: Code 0x1 (opcode[7:4]) branches when the operands are equal. Code 0x5 branches when they differ. Code 0x4 branches when their bitwise AND is nonzero.
- R5: Unsigned codes branch as follows: 0x2 when greater, 0x3 when greater or equal, 0xA when less, 0xB when less or equal.
- R6: Signed (two's complement) codes branch as follows: 0x6 when greater, 0x7 when greater or equal, 0xC when less, 0xD when less or equal.
- R7: Code 0x0 in class 0x05 always branches.
- R8: A taken branch sets `taken_o` and loads PC + sign-extended offset. A branch not taken loads PC + 1. Both wrap modulo 2^PC_W.
- R9: Code 0x8 in either jump class sets `call_o`, leaves `taken_o` low and advances the PC by 1.
- R10: Code 0x9 in class 0x05 sets `ret_o` and holds the PC.
- R11: The following assert `bad_o`, hold the PC and leave all other flags low: code 0xE or 0xF, code 0x0 or 0x9 in class 0x06, or any class other than 0x05 and 0x06.
- R12: The result appears one cycle after `op_valid`. On cycles with no result, `res_valid` and all flags are 0 and the PC holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Instruction present this cycle |
| opcode | input | 8 | Condition code [7:4], operand select [3], class [2:0] |
| dst_val | input | XLEN | First compare operand |
| src_val | input | XLEN | Register second operand |
| imm | input | IMM_W | Immediate second operand |
| offset | input | OFF_W | Signed branch displacement in slots |
| res_valid | output | 1 | Result flags valid |
| pc_o | output | PC_W | Registered program counter |
| taken_o | output | 1 | Branch taken |
| call_o | output | 1 | Call operation |
| ret_o | output | 1 | Return operation |
| bad_o | output | 1 | Illegal encoding |

## Verification
The bench sweeps every condition code in both classes and with both operand sources. It uses operand pairs on which the 64-bit and 32-bit views disagree: the high halves differ while the low halves are equal, or bit 31 is set while the upper bits are clear. A unit that compared the wrong width, or treated signed as unsigned, would branch the wrong way on these pairs. All-ones immediates expose a zero-extended immediate, because it would no longer equal an all-ones register. Negative offsets from small PC values check wraparound. The unconditional and return codes in the 32-bit class, the unused codes and the foreign classes must hold the PC. A unit that advanced or jumped on these would leave the running PC model behind for the rest of the sweep.

// File: rtl/bcu_pkg.sv
`timescale 1ns/1ps
package bcu_pkg;
  // instruction class values in opcode[2:0]
  localparam logic [2:0] CLS_WIDE   = 3'h5;
  localparam logic [2:0] CLS_NARROW = 3'h6;

  // condition codes in opcode[7:4]
  localparam logic [3:0] OP_ALWAYS = 4'h0;
  localparam logic [3:0] OP_EQ     = 4'h1;
  localparam logic [3:0] OP_UGT    = 4'h2;
  localparam logic [3:0] OP_UGE    = 4'h3;
  localparam logic [3:0] OP_BITS   = 4'h4;
  localparam logic [3:0] OP_NE     = 4'h5;
  localparam logic [3:0] OP_SGT    = 4'h6;
  localparam logic [3:0] OP_SGE    = 4'h7;
  localparam logic [3:0] OP_CALL   = 4'h8;
  localparam logic [3:0] OP_RET    = 4'h9;
  localparam logic [3:0] OP_ULT    = 4'ha;
  localparam logic [3:0] OP_ULE    = 4'hb;
  localparam logic [3:0] OP_SLT    = 4'hc;
  localparam logic [3:0] OP_SLE    = 4'hd;

  typedef struct packed {
    logic taken;
    logic call;
    logic ret;
    logic bad;
  } bcu_flags_t;
endpackage

// File: rtl/bcu_cmp.sv
`timescale 1ns/1ps
// Raw relations between two operands of one width.
module bcu_cmp #(
  parameter int W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         eq,
  output logic         ult,
  output logic         slt,
  output logic         nz
);
  always_comb begin
    eq  = (a == b);
    ult = (a < b);
    slt = ($signed(a) < $signed(b));
    nz  = |(a & b);
  end
endmodule

// File: rtl/bcu_operand_sel.sv
`timescale 1ns/1ps
// Second operand: register or sign-extended immediate.
module bcu_operand_sel #(
  parameter int XLEN  = 64,
  parameter int IMM_W = 32
) (
  input  logic             use_reg,
  input  logic [XLEN-1:0]  src,
  input  logic [IMM_W-1:0] imm,
  output logic [XLEN-1:0]  b
);
  localparam int EXT_W = XLEN - IMM_W;

  logic [XLEN-1:0] imm_x;
  assign imm_x = {{EXT_W{imm[IMM_W-1]}}, imm};
  assign b     = use_reg ? src : imm_x;
endmodule

// File: rtl/bcu_cond.sv
`timescale 1ns/1ps
// Predicate evaluation for both compare widths.
module bcu_cond
  import bcu_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [3:0]      code,
  input  logic            narrow,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic            hit
);
  localparam int NW = 2;

  logic [NW-1:0] eq_v, ult_v, slt_v, nz_v;

  // index 0: full width, index 1: low half
  for (genvar g = 0; g < NW; g++) begin : g_width
    localparam int W = (g == 0) ? XLEN : XLEN / 2;
    bcu_cmp #(.W(W)) u_cmp (
      .a   (a[W-1:0]),
      .b   (b[W-1:0]),
      .eq  (eq_v[g]),
      .ult (ult_v[g]),
      .slt (slt_v[g]),
      .nz  (nz_v[g])
    );
  end

  logic eq, ult, slt, nz;
  always_comb begin
    eq  = narrow ? eq_v[1]  : eq_v[0];
    ult = narrow ? ult_v[1] : ult_v[0];
    slt = narrow ? slt_v[1] : slt_v[0];
    nz  = narrow ? nz_v[1]  : nz_v[0];
    unique case (code)
      OP_EQ:   hit = eq;
      OP_NE:   hit = !eq;
      OP_BITS: hit = nz;
      OP_UGT:  hit = !ult && !eq;
      OP_UGE:  hit = !ult;
      OP_ULT:  hit = ult;
      OP_ULE:  hit = ult || eq;
      OP_SGT:  hit = !slt && !eq;
      OP_SGE:  hit = !slt;
      OP_SLT:  hit = slt;
      OP_SLE:  hit = slt || eq;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/bcu_pc_next.sv
`timescale 1ns/1ps
// Next program counter: hold, jump by offset, or step one slot.
module bcu_pc_next #(
  parameter int PC_W  = 32,
  parameter int OFF_W = 16
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [OFF_W-1:0] off,
  input  logic             jump,
  input  logic             stay,
  output logic [PC_W-1:0]  nxt
);
  localparam int EXT_W = PC_W - OFF_W;

  logic [PC_W-1:0] off_x;
  assign off_x = {{EXT_W{off[OFF_W-1]}}, off};

  always_comb begin
    if (stay)      nxt = pc;
    else if (jump) nxt = pc + off_x;
    else           nxt = pc + 1'b1;
  end
endmodule

// File: rtl/bcu_branch_unit.sv
`timescale 1ns/1ps
module bcu_branch_unit
  import bcu_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IMM_W = 32,
  parameter int OFF_W = 16,
  parameter int PC_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [7:0]       opcode,
  input  logic [XLEN-1:0]  dst_val,
  input  logic [XLEN-1:0]  src_val,
  input  logic [IMM_W-1:0] imm,
  input  logic [OFF_W-1:0] offset,
  output logic             res_valid,
  output logic [PC_W-1:0]  pc_o,
  output logic             taken_o,
  output logic             call_o,
  output logic             ret_o,
  output logic             bad_o
);
  logic [2:0] cls;
  logic [3:0] code;
  logic       use_reg, narrow, cls_ok;

  assign cls     = opcode[2:0];
  assign code    = opcode[7:4];
  assign use_reg = opcode[3];
  assign narrow  = (cls == CLS_NARROW);
  assign cls_ok  = (cls == CLS_WIDE) || narrow;

  logic [XLEN-1:0] opnd_b;
  bcu_operand_sel #(.XLEN(XLEN), .IMM_W(IMM_W)) u_sel (
    .use_reg (use_reg),
    .src     (src_val),
    .imm     (imm),
    .b       (opnd_b)
  );

  logic hit;
  bcu_cond #(.XLEN(XLEN)) u_cond (
    .code   (code),
    .narrow (narrow),
    .a      (dst_val),
    .b      (opnd_b),
    .hit    (hit)
  );

  bcu_flags_t dec;
  always_comb begin
    dec = '0;
    unique case (code)
      OP_ALWAYS: begin
        dec.taken = !narrow;
        dec.bad   = narrow;
      end
      OP_RET: begin
        dec.ret = !narrow;
        dec.bad = narrow;
      end
      OP_CALL: dec.call = 1'b1;
      4'he, 4'hf: dec.bad = 1'b1;
      default: dec.taken = hit;
    endcase
    if (!cls_ok) dec = '{taken: 1'b0, call: 1'b0, ret: 1'b0, bad: 1'b1};
  end

  logic [PC_W-1:0] pc_nxt;
  bcu_pc_next #(.PC_W(PC_W), .OFF_W(OFF_W)) u_pc (
    .pc   (pc_o),
    .off  (offset),
    .jump (dec.taken),
    .stay (dec.bad || dec.ret),
    .nxt  (pc_nxt)
  );

  bcu_flags_t flags_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_o      <= '0;
      res_valid <= 1'b0;
      flags_q   <= '0;
    end else begin
      res_valid <= op_valid;
      if (op_valid) begin
        pc_o    <= pc_nxt;
        flags_q <= dec;
      end else begin
        flags_q <= '0;
      end
    end
  end

  assign taken_o = flags_q.taken;
  assign call_o  = flags_q.call;
  assign ret_o   = flags_q.ret;
  assign bad_o   = flags_q.bad;
endmodule

// File: rtl/bcu_branch_unit_chk.sv
`timescale 1ns/1ps
module bcu_branch_unit_chk #(
  parameter int OFF_W = 16,
  parameter int PC_W  = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       opcode,
  input logic [OFF_W-1:0] offset,
  input logic             res_valid,
  input logic [PC_W-1:0]  pc_o,
  input logic             taken_o,
  input logic             call_o,
  input logic             ret_o,
  input logic             bad_o
);
  logic [PC_W-1:0] off_x;
  assign off_x = {{(PC_W-OFF_W){offset[OFF_W-1]}}, offset};

  assert_flags_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $onehot0({taken_o, call_o, ret_o, bad_o}));

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (!taken_o && !call_o && !ret_o && !bad_o && $stable(pc_o)));

  assert_bad_holds_pc_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && bad_o) |-> (pc_o == $past(pc_o)));

  assert_ret_holds_pc_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ret_o |-> (pc_o == $past(pc_o) && $past(opcode[2:0]) == 3'h5));

  assert_call_steps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    call_o |-> (pc_o == $past(pc_o) + 1'b1));

  assert_fallthrough_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !taken_o && !ret_o && !bad_o) |-> (pc_o == $past(pc_o) + 1'b1));

  assert_taken_offset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> (pc_o == $past(pc_o) + $past(off_x)));

  assert_narrow_always_bad_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(opcode) == 8'h06) |-> bad_o);
endmodule

bind bcu_branch_unit bcu_branch_unit_chk #(.OFF_W(OFF_W), .PC_W(PC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .opcode    (opcode),
  .offset    (offset),
  .res_valid (res_valid),
  .pc_o      (pc_o),
  .taken_o   (taken_o),
  .call_o    (call_o),
  .ret_o     (ret_o),
  .bad_o     (bad_o)
);

// File: tb/sim_bcu_branch_unit.sv
`timescale 1ns/1ps
module sim_bcu_branch_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [7:0]  opcode = '0;
  logic [63:0] dst_val = '0;
  logic [63:0] src_val = '0;
  logic [31:0] imm = '0;
  logic [15:0] offset = '0;
  logic        res_valid;
  logic [31:0] pc_o;
  logic        taken_o, call_o, ret_o, bad_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] m_pc = '0;

  always #2 clk = ~clk;  // 250 MHz

  bcu_branch_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
    .dst_val(dst_val), .src_val(src_val), .imm(imm), .offset(offset),
    .res_valid(res_valid), .pc_o(pc_o), .taken_o(taken_o),
    .call_o(call_o), .ret_o(ret_o), .bad_o(bad_o)
  );

  // operand pairs where wide and narrow views disagree
  function automatic void pair(input int p, output logic [63:0] a, output logic [63:0] b);
    case (p)
      0: begin a = 64'd5;                   b = 64'd5; end
      1: begin a = 64'hFFFFFFFF_00000001;   b = 64'd2; end
      2: begin a = 64'h00000001_80000000;   b = 64'h00000001_7FFFFFFF; end
      3: begin a = 64'd0;                   b = 64'hFFFFFFFF_FFFFFFFF; end
      4: begin a = 64'h12345678_0000F0F0;   b = 64'h87654321_00000F0F; end
      5: begin a = 64'h80000000_00000000;   b = 64'h7FFFFFFF_FFFFFFFF; end
      6: begin a = 64'hDEADBEEF_CAFEF00D;   b = 64'h0BADF00D_CAFEF00D; end
      default: begin a = 64'hFFFFFFFF_FFFFFFFE; b = 64'hFFFFFFFF_FFFFFFFF; end
    endcase
  endfunction

  // reference model written from the requirements
  task automatic model(input logic [7:0] op, input logic [63:0] a, input logic [63:0] r,
                       input logic [31:0] im, output logic tk, output logic cl,
                       output logic rt, output logic bd, output string tag);
    logic [2:0] cls = op[2:0];
    logic [3:0] cd = op[7:4];
    logic [63:0] b, ua, ub, sa, sb;
    logic hit;
    tk = 0; cl = 0; rt = 0; bd = 0;
    b = op[3] ? r : {{32{im[31]}}, im};          // R3
    if (cls == 3'd6) begin                      // R2 narrow view
      ua = {32'd0, a[31:0]};           ub = {32'd0, b[31:0]};
      sa = {{32{a[31]}}, a[31:0]};     sb = {{32{b[31]}}, b[31:0]};
    end else begin
      ua = a; ub = b; sa = a; sb = b;
    end
    case (cd)
      4'h1: begin hit = (ua == ub); tag = "R4"; end
      4'h5: begin hit = (ua != ub); tag = "R4"; end
      4'h4: begin hit = ((ua & ub) != 0); tag = "R4"; end
      4'h2: begin hit = (ua > ub);  tag = "R5"; end
      4'h3: begin hit = (ua >= ub); tag = "R5"; end
      4'ha: begin hit = (ua < ub);  tag = "R5"; end
      4'hb: begin hit = (ua <= ub); tag = "R5"; end
      4'h6: begin hit = ($signed(sa) > $signed(sb));  tag = "R6"; end
      4'h7: begin hit = ($signed(sa) >= $signed(sb)); tag = "R6"; end
      4'hc: begin hit = ($signed(sa) < $signed(sb));  tag = "R6"; end
      4'hd: begin hit = ($signed(sa) <= $signed(sb)); tag = "R6"; end
      default: begin hit = 1'b0; tag = "R11"; end
    endcase
    if (cls != 3'd5 && cls != 3'd6) begin bd = 1; tag = "R11"; end
    else if (cd == 4'h0) begin
      if (cls == 3'd5) begin tk = 1; tag = "R7"; end else begin bd = 1; tag = "R11"; end
    end else if (cd == 4'h9) begin
      if (cls == 3'd5) begin rt = 1; tag = "R10"; end else begin bd = 1; tag = "R11"; end
    end else if (cd == 4'h8) begin cl = 1; tag = "R9"; end
    else if (cd >= 4'he) bd = 1;
    else tk = hit;
  endtask

  task automatic issue(input logic [7:0] op, input logic [63:0] a, input logic [63:0] r,
                       input logic [31:0] im, input logic [15:0] off);
    logic tk, cl, rt, bd;
    string tag;
    logic [31:0] exp_pc;
    model(op, a, r, im, tk, cl, rt, bd, tag);
    // R8: offset jump, one-slot step, or hold
    if (bd || rt) exp_pc = m_pc;
    else if (tk)  exp_pc = m_pc + {{16{off[15]}}, off};
    else          exp_pc = m_pc + 32'd1;
    @(negedge clk);
    op_valid = 1; opcode = op; dst_val = a; src_val = r; imm = im; offset = off;
    @(posedge clk); #1;
    n_chk++;
    if (res_valid !== 1'b1 || pc_o !== exp_pc || taken_o !== tk || call_o !== cl ||
        ret_o !== rt || bad_o !== bd) begin
      n_bad++;
      $display("FAIL %s (R8 R12) op=%h: pc=%h v=%b t=%b c=%b r=%b b=%b expected pc=%h v=1 t=%b c=%b r=%b b=%b",
               tag, op, pc_o, res_valid, taken_o, call_o, ret_o, bad_o, exp_pc, tk, cl, rt, bd);
    end
    m_pc = exp_pc;
  endtask

  task automatic idle_check();
    @(negedge clk);
    op_valid = 0; opcode = 8'h05; offset = 16'h7fff;
    @(posedge clk); #1;
    n_chk++;
    if (res_valid !== 0 || taken_o !== 0 || call_o !== 0 || ret_o !== 0 || bad_o !== 0 ||
        pc_o !== m_pc) begin
      n_bad++;
      $display("FAIL R12 idle: pc=%h v=%b flags=%b%b%b%b expected pc=%h v=0 flags=0000",
               pc_o, res_valid, taken_o, call_o, ret_o, bad_o, m_pc);
    end
  endtask

  initial begin
    #800000;
    n_chk++; n_bad++;
    $display("FAIL R12 watchdog: actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    n_chk++;  // R1
    if (pc_o !== 0 || res_valid !== 0 || taken_o !== 0 || call_o !== 0 || ret_o !== 0 || bad_o !== 0) begin
      n_bad++;
      $display("FAIL R1 reset: pc=%h v=%b flags=%b%b%b%b expected pc=0 v=0 flags=0000",
               pc_o, res_valid, taken_o, call_o, ret_o, bad_o);
    end
    // R2 R3 R4 R5 R6 R7 R9 R10 R11: full sweep of both jump classes
    for (int p = 0; p < 8; p++) begin
      logic [63:0] a, b;
      pair(p, a, b);
      for (int c = 5; c <= 6; c++)
        for (int s = 0; s < 2; s++)
          for (int cd = 0; cd < 16; cd++) begin
            n++;
            issue({cd[3:0], s[0], c[2:0]}, a, b, b[31:0], 16'(n * 2311 + 7));
          end
      idle_check();
    end
    // R11: foreign classes
    for (int c = 0; c < 8; c++) begin
      if (c == 5 || c == 6) continue;
      for (int cd = 0; cd < 16; cd += 3)
        issue({cd[3:0], 1'b1, c[2:0]}, 64'd1, 64'd1, 32'd1, 16'h0010);
    end
    idle_check();
    // R8: negative offset from a small PC wraps
    issue(8'h15, 64'd9, 64'd9, 32'd0, 16'h8000);
    issue(8'h1d, 64'd9, 64'd9, 32'd0, 16'hFFFF);
    idle_check();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule